// File: doc/BRIEF.md
# Block Transfer DMA Engine

This engine copies whole fixed-size blocks between a local block store and a buffer in host memory. Software sets three things: a block index that selects where the job starts in the local store, a byte address for the host buffer, and a count word. The count word gives the number of blocks and, in its top bit, the direction. Writing the count word launches the job. While the job runs, the engine moves one 32-bit word at a time. It reads the word from the source port, then writes it to the destination port. Each port uses a request/grant handshake.

The count register decrements after each block is finished, so it shows the work that remains and doubles as a busy indication. When the last block is done, the engine sets a pending completion flag. If that flag is enabled, it drives an interrupt line. Software clears the flag through the interrupt control register.

An error response on either memory port has three effects. It stops the job, it leaves the remaining count visible, and it sets a sticky error bit that software must clear before it starts again. Every register value crosses the register port with its four bytes reversed.

Top module: `blk_dma_engine`

## Requirements
- R1: The register port reverses byte order both ways. The engine uses the internal value `{d[7:0],d[15:8],d[23:16],d[31:24]}` of the write data `d`, and it returns a read value in the same reversed form. For example, a remaining count of 2 appears raw as 32'h0200_0000.
- R2: Register map by word index: 0 block index, 1 host byte address, 2 count, 3 status, 4 interrupt status, 5 interrupt control. Local store addressing works as follows:
  - The first local byte address is the block index times BLK_BYTES.
  - The first host byte address is the programmed value.
  - Both addresses step by 4 per word.
  - No words outside the job's range are touched.
- R3: Bit 31 of the count word sets the direction. With 1, data goes from host to local store. With 0, data goes from local store to host.
- R4: A count write starts a job whose block count is bits 15:0. A count of zero starts nothing, sets no flag and leaves the engine idle.
- R5: The count register reads the remaining blocks in bits 15:0, with all other bits zero. It drops by one after the last word of each block is written, and it reads zero when a job has completed.
- R6: Status bit 0 reads 1 from the cycle after the launching write until the job ends.
- R7: On completion, interrupt status bit 0 is set. Writing 1 to interrupt control bit 1 clears it.
- R8: Interrupt control bit 0 is an enable. The irq output is the pending flag ANDed with this enable.
- R9: A count write while a job runs is ignored. The remaining count and the direction are unchanged.
- R10: An error response has these effects:
  - It stops the job.
  - It leaves the count at its value at that moment.
  - It sets status bit 1 and does not set the pending flag.
  - Writing 1 to status bit 1 clears that bit.
- R11: At most one port request is active at a time. A request stays asserted, with a stable address, until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 3 | Register word index |
| csrWe | input | 1 | Register write strobe |
| csrWdata | input | 32 | Register write data, host byte order |
| csrRdata | output | 32 | Register read data, host byte order |
| locReq | output | 1 | Local store access request |
| locWe | output | 1 | Local store write (1) or read (0) |
| locAddr | output | LOC_AW | Local store byte address |
| locWdata | output | 32 | Local store write data |
| locRdata | input | 32 | Local store read data, valid with grant |
| locGnt | input | 1 | Local store access completes this cycle |
| locErr | input | 1 | Local store error response, with grant |
| hostReq | output | 1 | Host access request |
| hostWe | output | 1 | Host write (1) or read (0) |
| hostAddr | output | 32 | Host byte address |
| hostWdata | output | 32 | Host write data |
| hostRdata | input | 32 | Host read data, valid with grant |
| hostGnt | input | 1 | Host access completes this cycle |
| hostErr | input | 1 | Host error response, with grant |
| irq | output | 1 | Completion interrupt |

## Verification
Several internal faults show up at the ports:
- A wrong word counter or wrong pointer state appears at the ports in the first block. Data lands at the wrong destination word, or a word beyond the job is touched. The bench inspects these words after each job.
- A wrong remaining count is visible on the next register read. Polling during a stalled job catches a missed or double decrement within one block time.
- A stuck sequencer state either keeps status bit 0 high or leaves a request hanging. The hold and exclusivity properties flag a dropped or doubled request in the cycle it happens.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  localparam logic [2:0] REG_BLK    = 3'd0;
  localparam logic [2:0] REG_HOST   = 3'd1;
  localparam logic [2:0] REG_CNT    = 3'd2;
  localparam logic [2:0] REG_STAT   = 3'd3;
  localparam logic [2:0] REG_IRQST  = 3'd4;
  localparam logic [2:0] REG_IRQCTL = 3'd5;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // copy programmed bases into running pointers
    logic latch;    // capture source read data
    logic advance;  // step both pointers by one word
  } dpStrobe_t;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/blkdma_datapath.sv
module blkdma_datapath
  import blkdma_pkg::*;
#(
  parameter int LOC_AW    = 12,
  parameter int BLK_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrBlk,
  input  logic              wrHost,
  input  logic [31:0]       wVal,
  input  dpStrobe_t         strb,
  input  logic              dir,
  input  logic [31:0]       locRdata,
  input  logic [31:0]       hostRdata,
  output logic [31:0]       blkIdx,
  output logic [31:0]       hostBase,
  output logic [LOC_AW-1:0] locPtr,
  output logic [31:0]       hostPtr,
  output logic [31:0]       wordBuf
);

  logic [LOC_AW-1:0] locBase;
  assign locBase = LOC_AW'(blkIdx << BLK_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkIdx   <= '0;
      hostBase <= '0;
      locPtr   <= '0;
      hostPtr  <= '0;
      wordBuf  <= '0;
    end else begin
      if (wrBlk)  blkIdx   <= wVal;
      if (wrHost) hostBase <= wVal;
      if (strb.load) begin
        locPtr  <= locBase;
        hostPtr <= hostBase;
      end else if (strb.advance) begin
        locPtr  <= locPtr + LOC_AW'(4);
        hostPtr <= hostPtr + 32'd4;
      end
      if (strb.latch) wordBuf <= dir ? hostRdata : locRdata;
    end
  end

endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WPB   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCnt,
  input  logic             wrStat,
  input  logic             wrIrqCtl,
  input  logic [CNT_W-1:0] wrCntVal,
  input  logic             wrDir,
  input  logic             wrBit0,
  input  logic             wrBit1,
  input  logic             locGnt,
  input  logic             locErr,
  input  logic             hostGnt,
  input  logic             hostErr,
  output dpStrobe_t        strb,
  output logic             dir,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             errFlag,
  output logic             pend,
  output logic             irqEn,
  output logic             irq,
  output logic             locReq,
  output logic             locWe,
  output logic             hostReq,
  output logic             hostWe
);

  localparam int WC_W = (WPB > 1) ? $clog2(WPB) : 1;

  seqState_t       state;
  logic [WC_W-1:0] wordIdx;
  logic            srcGnt, srcErr, dstGnt, dstErr;
  logic            startHit, lastWord, rdPhase, wrPhase;

  assign rdPhase  = (state == S_RD);
  assign wrPhase  = (state == S_WR);
  assign busy     = (state != S_IDLE);
  assign srcGnt   = dir ? hostGnt : locGnt;
  assign srcErr   = dir ? hostErr : locErr;
  assign dstGnt   = dir ? locGnt  : hostGnt;
  assign dstErr   = dir ? locErr  : hostErr;
  assign startHit = wrCnt && !busy && (wrCntVal != '0);
  assign lastWord = (wordIdx == WC_W'(WPB - 1));

  assign locReq  = (rdPhase && !dir) || (wrPhase && dir);
  assign locWe   = wrPhase && dir;
  assign hostReq = (rdPhase && dir) || (wrPhase && !dir);
  assign hostWe  = wrPhase && !dir;
  assign irq     = pend && irqEn;

  always_comb begin
    strb         = '0;
    strb.load    = startHit;
    strb.latch   = rdPhase && srcGnt && !srcErr;
    strb.advance = wrPhase && dstGnt && !dstErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordIdx <= '0;
      cnt     <= '0;
      dir     <= 1'b0;
      errFlag <= 1'b0;
      pend    <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      if (wrStat && wrBit1) errFlag <= 1'b0;
      if (wrIrqCtl) begin
        irqEn <= wrBit0;
        if (wrBit1) pend <= 1'b0;
      end
      unique case (state)
        S_IDLE: begin
          if (startHit) begin
            cnt     <= wrCntVal;
            dir     <= wrDir;
            wordIdx <= '0;
            state   <= S_RD;
          end
        end
        S_RD: begin
          if (srcGnt) begin
            if (srcErr) begin
              errFlag <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state <= S_WR;
            end
          end
        end
        S_WR: begin
          if (dstGnt) begin
            if (dstErr) begin
              errFlag <= 1'b1;
              state   <= S_IDLE;
            end else if (lastWord) begin
              wordIdx <= '0;
              cnt     <= cnt - 1'b1;
              if (cnt == CNT_W'(1)) begin
                state <= S_IDLE;
                pend  <= 1'b1;
              end else begin
                state <= S_RD;
              end
            end else begin
              wordIdx <= wordIdx + 1'b1;
              state   <= S_RD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
  import blkdma_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int LOC_AW    = 12,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        csrAddr,
  input  logic              csrWe,
  input  logic [31:0]       csrWdata,
  output logic [31:0]       csrRdata,
  output logic              locReq,
  output logic              locWe,
  output logic [LOC_AW-1:0] locAddr,
  output logic [31:0]       locWdata,
  input  logic [31:0]       locRdata,
  input  logic              locGnt,
  input  logic              locErr,
  output logic              hostReq,
  output logic              hostWe,
  output logic [31:0]       hostAddr,
  output logic [31:0]       hostWdata,
  input  logic [31:0]       hostRdata,
  input  logic              hostGnt,
  input  logic              hostErr,
  output logic              irq
);

  localparam int BLK_SHIFT = $clog2(BLK_BYTES);
  localparam int WPB       = BLK_BYTES / 4;

  logic [31:0]      wVal, rVal, blkIdx, hostBase, wordBuf;
  logic [CNT_W-1:0] cnt;
  logic             dir, busy, errFlag, pend, irqEn;
  dpStrobe_t        strb;

  assign wVal = swap32(csrWdata);

  blkdma_ctrl #(.CNT_W(CNT_W), .WPB(WPB)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrCnt(csrWe && csrAddr == REG_CNT),
    .wrStat(csrWe && csrAddr == REG_STAT),
    .wrIrqCtl(csrWe && csrAddr == REG_IRQCTL),
    .wrCntVal(wVal[CNT_W-1:0]), .wrDir(wVal[31]),
    .wrBit0(wVal[0]), .wrBit1(wVal[1]),
    .locGnt(locGnt), .locErr(locErr), .hostGnt(hostGnt), .hostErr(hostErr),
    .strb(strb), .dir(dir), .cnt(cnt), .busy(busy), .errFlag(errFlag),
    .pend(pend), .irqEn(irqEn), .irq(irq),
    .locReq(locReq), .locWe(locWe), .hostReq(hostReq), .hostWe(hostWe)
  );

  blkdma_datapath #(.LOC_AW(LOC_AW), .BLK_SHIFT(BLK_SHIFT)) dp_i (
    .clk(clk), .rstN(rstN),
    .wrBlk(csrWe && csrAddr == REG_BLK),
    .wrHost(csrWe && csrAddr == REG_HOST),
    .wVal(wVal), .strb(strb), .dir(dir),
    .locRdata(locRdata), .hostRdata(hostRdata),
    .blkIdx(blkIdx), .hostBase(hostBase),
    .locPtr(locAddr), .hostPtr(hostAddr), .wordBuf(wordBuf)
  );

  assign locWdata  = wordBuf;
  assign hostWdata = wordBuf;

  always_comb begin
    case (csrAddr)
      REG_BLK:    rVal = blkIdx;
      REG_HOST:   rVal = hostBase;
      REG_CNT:    rVal = {{(32-CNT_W){1'b0}}, cnt};
      REG_STAT:   rVal = {30'd0, errFlag, busy};
      REG_IRQST:  rVal = {31'd0, pend};
      REG_IRQCTL: rVal = {31'd0, irqEn};
      default:    rVal = '0;
    endcase
  end

  assign csrRdata = swap32(rVal);

endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int LOC_AW = 12,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              locReq,
  input logic              locGnt,
  input logic [LOC_AW-1:0] locAddr,
  input logic              hostReq,
  input logic              hostGnt,
  input logic              hostErr,
  input logic [31:0]       hostAddr,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt
);

  // R11
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(locReq && hostReq));

  // R11
  loc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locReq && !locGnt) |=> (locReq && $stable(locAddr)));

  // R11
  host_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostGnt) |=> (hostReq && $stable(hostAddr)));

  // R5
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (cnt <= $past(cnt)));

  // R10
  err_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostGnt && hostErr) |=> !busy);

  // R4
  zero_cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> !(locReq || hostReq));

endmodule

bind blk_dma_engine blkdma_chk #(.LOC_AW(LOC_AW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .locReq(locReq), .locGnt(locGnt), .locAddr(locAddr),
  .hostReq(hostReq), .hostGnt(hostGnt), .hostErr(hostErr), .hostAddr(hostAddr),
  .busy(busy), .cnt(cnt)
);

// File: tb/tb_blk_dma_engine.sv
module tb_blk_dma_engine;
  import blkdma_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LOC_AW     = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        csrAddr = '0;
  logic              csrWe = 1'b0;
  logic [31:0]       csrWdata = '0;
  logic [31:0]       csrRdata;
  logic              locReq, locWe, hostReq, hostWe, irq;
  logic [LOC_AW-1:0] locAddr;
  logic [31:0]       locWdata, hostAddr, hostWdata, locRdata, hostRdata;
  logic              locGnt, hostGnt, locErr, hostErr;

  logic [31:0] locMem  [0:255];
  logic [31:0] hostMem [0:255];
  logic        stallMode = 1'b0;
  logic        tick = 1'b0;
  logic        errEn = 1'b0;
  logic [31:0] errAddr = '0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_dma_engine #(.BLK_BYTES(16), .LOC_AW(LOC_AW), .CNT_W(16)) dut (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata), .csrRdata(csrRdata),
    .locReq(locReq), .locWe(locWe), .locAddr(locAddr), .locWdata(locWdata),
    .locRdata(locRdata), .locGnt(locGnt), .locErr(locErr),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostGnt(hostGnt), .hostErr(hostErr), .irq(irq)
  );

  // memory models
  always @(posedge clk) tick <= ~tick;
  assign locGnt    = locReq && (!stallMode || tick);
  assign hostGnt   = hostReq && (!stallMode || tick);
  assign locErr    = 1'b0;
  assign hostErr   = hostGnt && errEn && (hostAddr == errAddr);
  assign locRdata  = locMem[locAddr[9:2]];
  assign hostRdata = hostMem[hostAddr[9:2]];

  always @(posedge clk) begin
    if (locReq && locWe && locGnt) locMem[locAddr[9:2]] <= locWdata;
    if (hostReq && hostWe && hostGnt && !hostErr) hostMem[hostAddr[9:2]] <= hostWdata;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    csrAddr  = a;
    csrWdata = swap32(v);
    csrWe    = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic wrRaw(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    csrAddr  = a;
    csrWdata = v;
    csrWe    = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic rdRaw(input logic [2:0] a, output logic [31:0] v);
    csrAddr = a;
    #1;
    v = csrRdata;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] v);
    logic [31:0] raw;
    rdRaw(a, raw);
    v = swap32(raw);
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rdReg(REG_STAT, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic fillMems();
    for (int i = 0; i < 256; i++) begin
      locMem[i]  = 32'hA000_0000 + i;
      hostMem[i] = 32'h5000_0000 + i;
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(REG_CNT, v);   check("R5 reset count", v, 32'd0);
    rdReg(REG_STAT, v);  check("R6 reset status", v, 32'd0);
    rdReg(REG_IRQST, v); check("R7 reset pending", v, 32'd0);
    check("R8 reset irq", {31'd0, irq}, 32'd0);
  endtask

  // local -> host, 2 blocks from block 3 to host 0x100
  task automatic testReadJob();
    logic [31:0] v;
    wrReg(REG_IRQCTL, 32'h1);
    wrReg(REG_BLK, 32'd3);
    wrReg(REG_HOST, 32'h100);
    wrReg(REG_CNT, 32'h0000_0002);
    rdReg(REG_STAT, v); check("R6 busy after launch", v & 32'h1, 32'h1);
    waitIdle();
    for (int w = 0; w < 8; w++)
      check("R2 R3 local to host word", hostMem[64 + w], 32'hA000_0000 + 32'(12 + w));
    check("R2 word past job untouched", hostMem[72], 32'h5000_0048);
    check("R2 word before job untouched", hostMem[63], 32'h5000_003F);
    rdReg(REG_CNT, v);   check("R5 count zero after job", v, 32'd0);
    rdReg(REG_IRQST, v); check("R7 pending set", v, 32'd1);
    check("R8 irq with enable", {31'd0, irq}, 32'd1);
    wrReg(REG_IRQCTL, 32'h3);
    rdReg(REG_IRQST, v); check("R7 pending cleared", v, 32'd0);
    rdReg(REG_IRQCTL, v); check("R8 enable kept", v, 32'd1);
    check("R8 irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  // host -> local, 3 blocks with stalls, ignored second count write
  task automatic testWriteJob();
    logic [31:0] v;
    bit sawTwo = 0;
    bit sawOne = 0;
    stallMode = 1'b1;
    wrReg(REG_IRQCTL, 32'h0);
    wrReg(REG_BLK, 32'd10);
    wrReg(REG_HOST, 32'h200);
    wrReg(REG_CNT, 32'h8000_0003);
    wrReg(REG_CNT, 32'h0000_0005);
    rdReg(REG_CNT, v); check("R9 count after ignored write", v, 32'd3);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rdReg(REG_CNT, v);
      if (v == 32'd2) sawTwo = 1;
      if (v == 32'd1) sawOne = 1;
      rdReg(REG_STAT, v);
      if (v[0] == 1'b0) break;
    end
    check("R5 live count passed 2", {31'd0, sawTwo}, 32'd1);
    check("R5 live count passed 1", {31'd0, sawOne}, 32'd1);
    for (int w = 0; w < 12; w++)
      check("R3 host to local word", locMem[40 + w], 32'h5000_0000 + 32'(128 + w));
    check("R9 direction kept, host intact", hostMem[128], 32'h5000_0080);
    check("R2 local past job untouched", locMem[52], 32'hA000_0034);
    rdReg(REG_IRQST, v); check("R7 pending after write job", v, 32'd1);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    wrReg(REG_IRQCTL, 32'h1);
    check("R8 irq after enable", {31'd0, irq}, 32'd1);
    wrReg(REG_IRQCTL, 32'h2);
    rdReg(REG_IRQST, v); check("R7 pending cleared again", v, 32'd0);
    stallMode = 1'b0;
  endtask

  task automatic testZeroCount();
    logic [31:0] v;
    wrReg(REG_CNT, 32'h8000_0000);
    rdReg(REG_STAT, v);  check("R4 zero count stays idle", v, 32'd0);
    rdReg(REG_IRQST, v); check("R4 zero count no pending", v, 32'd0);
    rdReg(REG_CNT, v);   check("R4 zero count reads zero", v, 32'd0);
  endtask

  // local -> host 3 blocks, error on block 1 word 1
  task automatic testError();
    logic [31:0] v;
    errEn   = 1'b1;
    errAddr = 32'h314;
    wrReg(REG_BLK, 32'd20);
    wrReg(REG_HOST, 32'h300);
    wrReg(REG_CNT, 32'h0000_0003);
    waitIdle();
    rdRaw(REG_CNT, v);   check("R10 R1 raw count after abort", v, 32'h0200_0000);
    rdReg(REG_STAT, v);  check("R10 error bit set", v, 32'd2);
    rdReg(REG_IRQST, v); check("R10 no pending on abort", v, 32'd0);
    check("R10 word before error written", hostMem[196], 32'hA000_0054);
    check("R10 erroring word not written", hostMem[197], 32'h5000_00C5);
    check("R10 later block untouched", hostMem[200], 32'h5000_00C8);
    wrReg(REG_STAT, 32'h2);
    rdReg(REG_STAT, v);  check("R10 error cleared", v, 32'd0);
    rdReg(REG_CNT, v);   check("R10 count kept", v, 32'd2);
    errEn = 1'b0;
  endtask

  task automatic testSwap();
    logic [31:0] v;
    wrRaw(REG_HOST, 32'h0000_0100);
    rdRaw(REG_HOST, v); check("R1 raw round trip", v, 32'h0000_0100);
    rdReg(REG_HOST, v); check("R1 internal value", v, 32'h0001_0000);
    wrRaw(REG_BLK, 32'h0100_0000);
    wrReg(REG_HOST, 32'h80);
    wrRaw(REG_CNT, 32'h0100_0000);
    waitIdle();
    for (int w = 0; w < 4; w++)
      check("R1 R2 swapped block index", hostMem[32 + w], 32'hA000_0000 + 32'(4 + w));
  endtask

  initial begin
    fillMems();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadJob();
    testWriteJob();
    testZeroCount();
    testError();
    testSwap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule